// File: doc/BRIEF.md
# Processor sleep and wake controller

This block holds a processor core in a low-power wait state and brings it back out. Software sets a wait bit through a register write strobe. From then on only the interrupt-detection path is active, and it runs on a free-running always-on clock. The first interrupt request whose enable bit is set clears the wait bit. In the same clock edge the block issues a one-cycle wake pulse, and the core resumes at the instruction after the one that started the wait.

While the core waits, an external stop input can gate the processor clock off and later back on. Releasing stop puts the core back in the wait state, not into execution. A stop request while the core runs is ignored. A write to the wait bit counts only while the processor clock is present. A separate PLL enable flag, written through its own strobe, keeps its value across the whole wait.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `asleep`=0, `wake`=0, `core_ce`=1 and `pll_on`=0 after that edge.
- R2: A write (`wr_strobe`=1) with `wr_wait`=1 while `clk_present`=1 and the core is awake sets `asleep` to 1 at the next edge.
- R3: A wait write made while `clk_present`=0 is ignored, so `asleep` stays 0.
- R4: A write with `wr_wait`=0 while awake has no effect, so `asleep` stays 0.
- R5: A request wakes the core when, for some bit i, `irq_req[i]`=1 and `irq_en[i]`=1. If this holds while the core is asleep and the clock is not stopped, the next edge drives `asleep` to 0 and `wake` to 1 together, and `wake` returns to 0 one edge later.
- R6: Requests whose enable bit is 0 never wake the core. Requests seen while the core is awake never produce a `wake` pulse.
- R7: `stop_in`=1 at an edge while asleep drives `core_ce` to 0 after that edge. `stop_in`=0 at a later edge drives `core_ce` back to 1, and `asleep` stays 1.
- R8: `stop_in` has no effect on `core_ce` while the core is awake.
- R9: `pll_on` follows `pll_wr_data` on a `pll_wr` strobe while awake. It holds its value through the wait and after wake-up, and PLL writes are ignored while asleep.
- R10: While the clock is stopped, enabled requests do not wake the core. A request still present after stop is released wakes the core one edge after `core_ce` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_strobe | input | 1 | Control register write strobe |
| wr_wait | input | 1 | Wait bit value carried by the write |
| clk_present | input | 1 | High while the processor clock is running |
| pll_wr | input | 1 | PLL flag write strobe |
| pll_wr_data | input | 1 | PLL flag value carried by the write |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line interrupt enable |
| stop_in | input | 1 | External clock stop request |
| core_ce | output | 1 | Processor core clock enable |
| asleep | output | 1 | Wait bit / sleep status |
| wake | output | 1 | One-cycle wake pulse |
| pll_on | output | 1 | PLL enable flag |

## Verification
Wake detection is swept over every pair of request and enable patterns on a four-line build. Each pair starts from a fresh sleep, and the wake or its absence is compared with the bitwise AND of the two patterns. This separates enabled, masked and idle lines, and it exposes any line that is wired wrongly or ignores its enable. Directed sequences cover the stop input. They apply stop while awake and while asleep, raise a request during a stop and then release the stop, which separates gating during sleep from gating during execution. They also apply wait writes with no clock present, wait writes of zero, and PLL writes across a full sleep and wake cycle.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_strobe,
  input  logic            wr_wait,
  input  logic            clk_present,
  input  logic            pll_wr,
  input  logic            pll_wr_data,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            stop_in,
  output logic            core_ce,
  output logic            asleep,
  output logic            wake,
  output logic            pll_on
);

  logic sleep_q, stopped_q, wake_q, pll_q;
  logic hit, wake_now, enter_now;

  assign hit       = |(irq_req & irq_en);
  assign wake_now  = sleep_q & ~stopped_q & hit;
  assign enter_now = wr_strobe & wr_wait & clk_present & ~sleep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q   <= 1'b0;
      stopped_q <= 1'b0;
      wake_q    <= 1'b0;
      pll_q     <= 1'b0;
    end else begin
      wake_q    <= wake_now;
      stopped_q <= sleep_q & ~wake_now & stop_in;
      if (wake_now)       sleep_q <= 1'b0;
      else if (enter_now) sleep_q <= 1'b1;
      if (pll_wr && !sleep_q) pll_q <= pll_wr_data;
    end
  end

  assign core_ce = ~stopped_q;
  assign asleep  = sleep_q;
  assign wake    = wake_q;
  assign pll_on  = pll_q;

endmodule

module sleep_wake_ctrl_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_strobe,
  input logic            wr_wait,
  input logic            clk_present,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            stop_in,
  input logic            core_ce,
  input logic            asleep,
  input logic            wake,
  input logic            pll_on
);
  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe && wr_wait && clk_present && !asleep) |=> asleep); // R2
  AST_NO_CLK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!asleep && !(wr_strobe && wr_wait && clk_present)) |=> !asleep); // R3
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake); // R5
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wake |-> (!asleep && $past(asleep))); // R5
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (asleep && ((irq_req & irq_en) == '0)) |=> (asleep && !wake)); // R6
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (rst)
    (asleep && stop_in) |=> (!core_ce || wake)); // R7
  AST_AWAKE_CE: assert property (@(posedge clk) disable iff (rst)
    !asleep |-> core_ce); // R8
  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    asleep |=> $stable(pll_on)); // R9
  AST_STOPPED_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    !core_ce |=> !wake); // R10
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_wait(wr_wait),
  .clk_present(clk_present), .irq_req(irq_req), .irq_en(irq_en),
  .stop_in(stop_in), .core_ce(core_ce), .asleep(asleep), .wake(wake),
  .pll_on(pll_on)
);

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;
  localparam int NIRQ = 4;
  localparam int NPAT = 1 << NIRQ;

  logic clk = 1'b0;
  logic rst, wr_strobe, wr_wait, clk_present, pll_wr, pll_wr_data, stop_in;
  logic [NIRQ-1:0] irq_req, irq_en;
  logic core_ce, asleep, wake, pll_on;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.NIRQ(NIRQ)) dut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_wait(wr_wait),
    .clk_present(clk_present), .pll_wr(pll_wr), .pll_wr_data(pll_wr_data),
    .irq_req(irq_req), .irq_en(irq_en), .stop_in(stop_in),
    .core_ce(core_ce), .asleep(asleep), .wake(wake), .pll_on(pll_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wait_write(input logic v);
    wr_strobe = 1'b1; wr_wait = v;
    tick();
    wr_strobe = 1'b0; wr_wait = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; wr_strobe = 1'b0; wr_wait = 1'b0; clk_present = 1'b1;
    pll_wr = 1'b0; pll_wr_data = 1'b0; stop_in = 1'b0;
    irq_req = '0; irq_en = '0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R1 core_ce", core_ce, 1'b1);
    chk("R1 pll_on", pll_on, 1'b0);

    pll_wr = 1'b1; pll_wr_data = 1'b1; tick(); pll_wr = 1'b0;
    chk("R9 pll write awake", pll_on, 1'b1);

    do_wait_write(1'b0);
    chk("R4 zero write", asleep, 1'b0);

    clk_present = 1'b0;
    do_wait_write(1'b1);
    chk("R3 no clock write", asleep, 1'b0);
    clk_present = 1'b1;

    stop_in = 1'b1;
    tick(); chk("R8 stop awake", core_ce, 1'b1);
    tick(); chk("R8 stop awake hold", core_ce, 1'b1);
    stop_in = 1'b0;

    do_wait_write(1'b1);
    chk("R2 enter", asleep, 1'b1);
    chk("R2 no wake", wake, 1'b0);

    pll_wr = 1'b1; pll_wr_data = 1'b0; tick(); pll_wr = 1'b0;
    chk("R9 pll write asleep ignored", pll_on, 1'b1);

    stop_in = 1'b1; tick();
    chk("R7 stop gates", core_ce, 1'b0);
    irq_en = 4'b0100; irq_req = 4'b0100; tick();
    chk("R10 no wake while stopped", wake, 1'b0);
    chk("R10 still asleep", asleep, 1'b1);
    stop_in = 1'b0; tick();
    chk("R7 release ce", core_ce, 1'b1);
    chk("R7 release still asleep", asleep, 1'b1);
    chk("R10 no wake at release", wake, 1'b0);
    tick();
    chk("R10 wake after release", wake, 1'b1);
    chk("R5 asleep cleared", asleep, 1'b0);
    tick();
    chk("R5 pulse ends", wake, 1'b0);
    chk("R9 pll kept after wake", pll_on, 1'b1);

    tick();
    chk("R6 awake request no wake", wake, 1'b0);
    irq_req = '0; irq_en = '0;

    do_wait_write(1'b1);
    stop_in = 1'b1; tick();
    chk("R7 gated before reset", core_ce, 1'b0);
    rst = 1'b1; tick(); rst = 1'b0; stop_in = 1'b0;
    chk("R1 reset from stop ce", core_ce, 1'b1);
    chk("R1 reset from stop asleep", asleep, 1'b0);
    chk("R1 reset pll", pll_on, 1'b0);

    for (int e = 0; e < NPAT; e++) begin
      for (int r = 0; r < NPAT; r++) begin
        logic exp_w;
        exp_w = |(e[NIRQ-1:0] & r[NIRQ-1:0]);
        irq_req = '0; irq_en = '0;
        do_wait_write(1'b1);
        irq_en = e[NIRQ-1:0]; irq_req = r[NIRQ-1:0];
        tick();
        chk(exp_w ? "R5 sweep wake" : "R6 sweep no wake", wake, exp_w);
        chk(exp_w ? "R5 sweep asleep" : "R6 sweep asleep", asleep, ~exp_w);
        if (!exp_w) begin
          irq_en = '1; irq_req = 4'b0001;
          tick();
        end
        irq_req = '0; irq_en = '0;
        tick();
        chk("R5 sweep pulse ends", wake, 1'b0);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule